// File: doc/BRIEF.md
# Banked SRAM Power-Gating Controller

This block sits between a single memory request port and an on-chip SRAM built from several equal banks. All banks but one can be switched off. The last bank is a retention bank: it is always powered and it is the only store whose contents outlast deep sleep. Each request carries a word address. The two address bits just above the in-bank word offset choose the bank. Only the chosen bank receives a chip enable, so the other banks see no switching.

Software sets the power of each bank through a write strobe and a mask. It can read the enables and a per-bank ready flag. A bank that has just been switched on waits a fixed settle time before it takes accesses. During that time a request to it is held with ready low. A request to a bank that is switched off completes at once with an error flag. A deep-sleep request switches off every bank except the retention bank in one cycle. Nothing is kept in a bank that was switched off: until a word is written again, a read of it returns a fixed poison word.

Top module: `sbg_ctrl`

## Requirements
- R1: The request address is a word address. Bits [11:10] select the bank and bits [9:0] select the word within the bank. Bank 3 is the retention bank.
- R2: `bank_sel_oh` is the one-hot code of the addressed bank in the cycle a request is accepted and that bank is powered. In every other cycle it is zero.
- R3: A read accepted on a ready, powered bank returns the last data written to that word. The data appears with `rsp_valid` high in the cycle after acceptance.
- R4: A `sleep_req` pulse clears the enable and ready bits of every gated bank at the next clock edge. Retention-bank data stays readable after deep sleep.
- R5: The retention bank's enable bit and ready bit always read 1. A mask that writes 0 to that bit has no effect on it. After reset, the gated banks are off.
- R6: When a gated bank's enable goes from 0 to 1, its ready bit stays low for SETTLE_CYC clock edges and then goes high. While the addressed bank is enabled but not ready, `req_ready` is low.
- R7: A request to a disabled bank is accepted without a stall. It enables no bank, and the next cycle shows `rsp_valid` and `rsp_err` high.
- R8: After a gated bank is powered up again, a read of any word not written since power-up returns 32'hBAD0_BAD0.
- R9: When `sleep_req` and `pwr_wr` are high in the same cycle, sleep wins and all gated banks go off.
- R10: In reset, `pwr_en` and `bank_ready` both read 4'b1000 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address: bits [11:10] are the bank, bits [9:0] the word |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Low while the addressed bank is settling |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_err | output | 1 | Request hit a disabled bank |
| rsp_rdata | output | 32 | Read data |
| pwr_wr | input | 1 | Load the power-enable mask |
| pwr_wdata | input | 4 | New per-bank enable mask |
| sleep_req | input | 1 | Deep-sleep entry pulse |
| pwr_en | output | 4 | Per-bank power enable |
| bank_ready | output | 4 | Per-bank powered-and-settled flag |
| bank_sel_oh | output | 4 | Per-bank chip enable for the current cycle |

## Verification
The assertions check on every cycle that at most one bank is enabled, that ready is never set on a disabled bank, that a bank whose enable has just risen is not ready and stalls requests to it, that requests to disabled banks enable nothing and come back flagged as errors, and that deep sleep (with priority over a mask write) leaves only the retention bank on. Other behaviour depends on state built up over a whole scenario, so only the bench can show it. This covers read data matching earlier writes, the poison word after a power cycle, retention data outlasting sleep, and the exact number of settle edges.

// File: rtl/sbg_pkg.sv
// Shared constants for the banked SRAM power-gating controller.
// Assumes 32-bit memory words and a fixed poison word for lost contents.
package sbg_pkg;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] POISON_WORD = 32'hBAD0_BAD0;
endpackage

// File: rtl/sbg_decode.sv
// Address decoder: splits a word address into bank index, in-bank word
// index and a one-hot bank code. Assumes NUM_BANKS is a power of two.
module sbg_decode #(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_WORDS = 1024,
    localparam int OFF_W  = $clog2(BANK_WORDS),
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic [OFF_W+BANK_W-1:0] addr,
    output logic [BANK_W-1:0]       bank_idx,
    output logic [OFF_W-1:0]        word_idx,
    output logic [NUM_BANKS-1:0]    bank_oh
);
    // Field split and one-hot expansion of the bank field.
    always_comb begin
        bank_idx = addr[OFF_W+BANK_W-1:OFF_W];
        word_idx = addr[OFF_W-1:0];
        bank_oh  = '0;
        bank_oh[bank_idx] = 1'b1;
    end
endmodule

// File: rtl/sbg_pwr_ctl.sv
// Power-state holder: one enable bit and one settle counter per gated bank.
// The retention bank is always enabled and ready. Deep sleep outranks a
// mask write. A bank counts as ready only when enabled and its counter is 0.
module sbg_pwr_ctl #(
    parameter int NUM_BANKS  = 4,
    parameter int RET_IDX    = NUM_BANKS - 1,
    parameter int SETTLE_CYC = 8,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_wr,
    input  logic [NUM_BANKS-1:0] pwr_wdata,
    input  logic                 sleep_req,
    output logic [NUM_BANKS-1:0] pwr_en,
    output logic [NUM_BANKS-1:0] bank_ready
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        if (g == RET_IDX) begin : g_ret
            // Retention bank: permanently on and settled.
            assign pwr_en[g]     = 1'b1;
            assign bank_ready[g] = 1'b1;
        end else begin : g_gated
            logic             en_q;
            logic             en_nxt;
            logic [CNT_W-1:0] cnt_q;

            // Next enable: sleep first, then software write, else hold.
            always_comb begin
                if (sleep_req)   en_nxt = 1'b0;
                else if (pwr_wr) en_nxt = pwr_wdata[g];
                else             en_nxt = en_q;
            end

            // Enable register and settle countdown started on each power-up.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q  <= 1'b0;
                    cnt_q <= '0;
                end else begin
                    en_q <= en_nxt;
                    if (en_nxt && !en_q)    cnt_q <= CNT_W'(SETTLE_CYC);
                    else if (!en_nxt)       cnt_q <= '0;
                    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
                end
            end

            assign pwr_en[g]     = en_q;
            assign bank_ready[g] = en_q && (cnt_q == '0);
        end
    end
endmodule

// File: rtl/sbg_bank.sv
// Behavioural SRAM bank with a per-word valid map. While the bank is
// unpowered the map is cleared, so an unwritten word reads as the poison
// word after power-up. Reads are registered (one-cycle latency).
module sbg_bank
    import sbg_pkg::*;
#(
    parameter int BANK_WORDS = 1024,
    localparam int OFF_W = $clog2(BANK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              ce,
    input  logic              we,
    input  logic [OFF_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0]     mem [BANK_WORDS];
    logic [BANK_WORDS-1:0] valid_q;

    // Array write port.
    always_ff @(posedge clk) begin
        if (ce && we) mem[widx] <= wdata;
    end

    // Valid map: lost on power-off, set on each write.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on)  valid_q <= '0;
        else if (ce && we)      valid_q[widx] <= 1'b1;
    end

    // Registered read port returning poison for words never written.
    always_ff @(posedge clk) begin
        if (!rst_n)             rdata <= '0;
        else if (ce && !we)     rdata <= valid_q[widx] ? mem[widx] : POISON_WORD;
    end
endmodule

// File: rtl/sbg_ctrl.sv
// Banked SRAM power-gating controller (top). Decodes each request to one
// bank and enables only that bank. Stalls requests to settling banks and
// answers requests to disabled banks with an error. Assumes one request
// port, a one-cycle response and a word address.
module sbg_ctrl
    import sbg_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_WORDS = 1024,
    parameter int SETTLE_CYC = 8,
    localparam int OFF_W  = $clog2(BANK_WORDS),
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int ADDR_W = OFF_W + BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 pwr_wr,
    input  logic [NUM_BANKS-1:0] pwr_wdata,
    input  logic                 sleep_req,
    output logic [NUM_BANKS-1:0] pwr_en,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic [NUM_BANKS-1:0] bank_sel_oh
);
    localparam int RET_IDX = NUM_BANKS - 1;

    logic [BANK_W-1:0]    acc_bank;
    logic [OFF_W-1:0]     acc_word;
    logic [NUM_BANKS-1:0] acc_oh;
    logic                 accept, hit, miss;
    logic [BANK_W-1:0]    sel_q;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    sbg_decode #(.NUM_BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS)) u_dec (
        .addr     (req_addr),
        .bank_idx (acc_bank),
        .word_idx (acc_word),
        .bank_oh  (acc_oh)
    );

    sbg_pwr_ctl #(.NUM_BANKS(NUM_BANKS), .RET_IDX(RET_IDX),
                  .SETTLE_CYC(SETTLE_CYC)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_wr     (pwr_wr),
        .pwr_wdata  (pwr_wdata),
        .sleep_req  (sleep_req),
        .pwr_en     (pwr_en),
        .bank_ready (bank_ready)
    );

    // Handshake and bank chip-enable generation.
    always_comb begin
        req_ready   = !(req_valid && pwr_en[acc_bank] && !bank_ready[acc_bank]);
        accept      = req_valid && req_ready;
        hit         = accept && pwr_en[acc_bank];
        miss        = accept && !pwr_en[acc_bank];
        bank_sel_oh = hit ? acc_oh : '0;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_mem
        sbg_bank #(.BANK_WORDS(BANK_WORDS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_on (pwr_en[g]),
            .ce     (bank_sel_oh[g]),
            .we     (req_we),
            .widx   (acc_word),
            .wdata  (req_wdata),
            .rdata  (bank_rdata[g])
        );
    end

    // Response pipeline stage: valid, error and the bank to read from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            sel_q     <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_err   <= miss;
            if (hit) sel_q <= acc_bank;
        end
    end

    // Read-data return mux, zero on error or idle.
    always_comb begin
        rsp_rdata = (rsp_valid && !rsp_err) ? bank_rdata[sel_q] : '0;
    end
endmodule

// File: rtl/sbg_ctrl_chk.sv
// Assertion checker for sbg_ctrl, attached by bind. Observes only ports.
module sbg_ctrl_chk #(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_WORDS = 1024,
    localparam int OFF_W  = $clog2(BANK_WORDS),
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int ADDR_W = OFF_W + BANK_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic                 pwr_wr,
    input logic                 sleep_req,
    input logic [NUM_BANKS-1:0] pwr_en,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic [NUM_BANKS-1:0] bank_sel_oh
);
    localparam logic [NUM_BANKS-1:0] RET_MASK = {1'b1, {(NUM_BANKS-1){1'b0}}};

    logic [BANK_W-1:0] a_bank;
    assign a_bank = req_addr[ADDR_W-1:OFF_W];

    // R2: never more than one bank enabled.
    p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel_oh));

    // R2: no chip enable without a request.
    p_idle_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> bank_sel_oh == '0);

    // R6: ready only on enabled banks.
    p_ready_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ready & ~pwr_en) == '0);

    // R6: a request to a settling bank is stalled.
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pwr_en[a_bank] && !bank_ready[a_bank]) |-> !req_ready);

    // R7: a request to a disabled bank enables nothing and errors next cycle.
    p_err_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pwr_en[a_bank]) |-> (req_ready && bank_sel_oh == '0));
    p_err_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pwr_en[a_bank]) |=> (rsp_valid && rsp_err));

    // R3: every accepted request gets a response next cycle.
    p_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R4 and R9: sleep leaves only the retention bank on, even with a write.
    p_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (pwr_en == RET_MASK && bank_ready == RET_MASK));
    p_sleep_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && pwr_wr) |=> pwr_en == RET_MASK);

    // R6: a freshly enabled gated bank is not yet ready.
    for (genvar g = 0; g < NUM_BANKS - 1; g++) begin : g_rise
        p_rise_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_en[g]) |-> !bank_ready[g]);
    end
endmodule

bind sbg_ctrl sbg_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .pwr_wr      (pwr_wr),
    .sleep_req   (sleep_req),
    .pwr_en      (pwr_en),
    .bank_ready  (bank_ready),
    .bank_sel_oh (bank_sel_oh)
);

// File: tb/tb_sbg_ctrl.sv
module tb_sbg_ctrl;
    localparam int NB = 4, BW = 1024, SETTLE = 8;
    localparam logic [31:0] POISON = 32'hBAD0_BAD0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        pwr_wr = 1'b0, sleep_req = 1'b0;
    logic [3:0]  pwr_wdata = '0;
    logic [3:0]  pwr_en, bank_ready, bank_sel_oh;

    int total = 0, bad = 0;
    bit done = 1'b0;

    bit [31:0] ref_mem [NB][BW];
    bit        ref_ok  [NB][BW];
    bit [3:0]  ref_en = 4'b1000;

    always #10 clk = ~clk;

    sbg_ctrl #(.NUM_BANKS(NB), .BANK_WORDS(BW), .SETTLE_CYC(SETTLE)) dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_read(int b, int w);
        return ref_ok[b][w] ? ref_mem[b][w] : POISON;
    endfunction

    function automatic void forget(int b);
        for (int w = 0; w < BW; w++) ref_ok[b][w] = 1'b0;
    endfunction

    // One request, waiting through any stall; checks R2, R3, R7, R8.
    task automatic access(bit we, int b, int w, bit [31:0] d);
        bit on;
        bit [31:0] exp;
        on  = ref_en[b];
        exp = exp_read(b, w);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = {2'(b), 10'(w)}; req_wdata = d;
        #1;
        while (!req_ready) begin
            chk("R2 no enable while stalled", 32'(bank_sel_oh), 32'h0);
            @(negedge clk); #1;
        end
        chk("R2 bank enable", 32'(bank_sel_oh), on ? (32'h1 << b) : 32'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 error flag", {rsp_valid, rsp_err}, {1'b1, !on});
        if (on && we) begin
            ref_mem[b][w] = d; ref_ok[b][w] = 1'b1;
        end else if (on) begin
            chk(ref_ok[b][w] ? "R3 read data" : "R8 poison data", rsp_rdata, exp);
        end
    endtask

    task automatic set_pwr(bit [3:0] m);
        @(negedge clk);
        pwr_wr = 1'b1; pwr_wdata = m;
        @(negedge clk);
        pwr_wr = 1'b0;
        for (int b = 0; b < NB - 1; b++) if (!m[b]) forget(b);
        ref_en = m | 4'b1000;
        chk("R5 enable mask", 32'(pwr_en), 32'(ref_en));
    endtask

    task automatic wait_ready();
        while (bank_ready != ref_en) @(negedge clk);
    endtask

    task automatic go_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        for (int b = 0; b < NB - 1; b++) forget(b);
        ref_en = 4'b1000;
        chk("R4 enables after sleep", 32'(pwr_en), 32'h8);
        chk("R4 ready after sleep", 32'(bank_ready), 32'h8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset pwr_en", 32'(pwr_en), 32'h8);
        chk("R10 reset ready", 32'(bank_ready), 32'h8);
        chk("R10 reset rsp_valid", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;

        // R1 retention bank (addr bits [11:10]=3) usable at once
        access(1'b1, 3, 5, 32'h1234_5678);
        access(1'b0, 3, 5, 0);
        // R7 disabled bank errors
        access(1'b1, 1, 7, 32'hAAAA_0001);
        access(1'b0, 0, 0, 0);

        // R6 exact settle count and stall
        @(negedge clk);
        pwr_wr = 1'b1; pwr_wdata = 4'b0001;
        @(negedge clk);
        pwr_wr = 1'b0; ref_en = 4'b1001;
        chk("R6 not ready after enable", 32'(bank_ready[0]), 32'h0);
        req_valid = 1'b1; req_we = 1'b0; req_addr = {2'd0, 10'd3}; #1;
        chk("R6 stall while settling", 32'(req_ready), 32'h0);
        @(negedge clk); req_valid = 1'b0;
        repeat (SETTLE - 2) @(negedge clk);
        chk("R6 still settling at edge S-1", 32'(bank_ready[0]), 32'h0);
        @(negedge clk);
        chk("R6 ready at edge S", 32'(bank_ready[0]), 32'h1);

        // R8 fresh bank reads poison; R3 write/read
        access(1'b0, 0, 3, 0);
        access(1'b1, 0, 3, 32'hCAFE_0003);
        access(1'b0, 0, 3, 0);

        // R5 retention enable cannot be cleared
        set_pwr(4'b0000);
        access(1'b0, 3, 5, 0);

        // R4 deep sleep: retention survives, gated bank loses data (R8)
        set_pwr(4'b0111); wait_ready();
        access(1'b1, 2, 9, 32'h0BAD_F00D);
        access(1'b1, 3, 9, 32'h600D_F00D);
        go_sleep();
        access(1'b0, 3, 9, 0);
        access(1'b0, 2, 9, 0);
        set_pwr(4'b0100); wait_ready();
        access(1'b0, 2, 9, 0);

        // R9 sleep beats a simultaneous mask write
        @(negedge clk);
        pwr_wr = 1'b1; pwr_wdata = 4'b1111; sleep_req = 1'b1;
        @(negedge clk);
        pwr_wr = 1'b0; sleep_req = 1'b0;
        for (int b = 0; b < NB - 1; b++) forget(b);
        ref_en = 4'b1000;
        chk("R9 sleep priority", 32'(pwr_en), 32'h8);

        // Random mix of accesses, mask writes and sleeps
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 12;
            if (r == 0) begin
                set_pwr(4'($urandom)); wait_ready();
            end else if (r == 1) begin
                go_sleep();
            end else begin
                access(1'($urandom), $urandom % NB, $urandom % 16, $urandom);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule